// File: doc/BRIEF.md
# Parallel Peripheral Port Side

This block is one side of a bus-addressed parallel port adapter. A processor reaches it through a two-address window. One address holds an 8-bit control register. The other address is shared: it reaches either the data direction register or the pin data path, depending on one control bit. Each port pin is an output or an input according to its direction bit. An output pin drives the value held in the output register. An input pin is sampled into a register on every clock.

An input control line, C1, passes through a synchronizer and an edge detector. Software chooses which edge is active. The active edge sets a sticky flag, and a read of the pin data path clears that flag. While the flag and its enable bit are both set, an active-low interrupt request is asserted. A second control line, C2, can be made an output whose level comes from a control bit.

The control register uses these bit positions:

| Bit | Meaning |
|-----|---------|
| 0 | Interrupt enable |
| 1 | C1 edge select: 0 falling, 1 rising |
| 2 | Data address select: 0 direction register, 1 pin data path |
| 3 | C2 level |
| 4 | C2 manual mode |
| 5 | C2 direction: 1 output |
| 6 | Reads 0 |
| 7 | C1 flag, read-only |

Top module: `ppp_side`

## Requirements
- R1: After reset, all three registers are zero. So `pin_oe` = 0, `c2_oe` = 0, `irq_n` = 1, and a read of the control address returns 0x00.
- R2: With control bit 2 = 0, a write to the data address (`addr` = 0) loads the direction register and a read returns it. `pin_oe` equals the direction register, and nothing else changes it.
- R3: With control bit 2 = 1, a write to the data address loads the output register, which appears on `pin_out`. A read returns the output register bit for each pin whose direction bit is 1.
- R4: With control bit 2 = 1, a read returns the sampled pin level for each pin whose direction bit is 0. A change on `pin_in` shows in `rdata` one clock edge after it is applied.
- R5: With control bit 1 = 0, a high-to-low transition of `c1_in` sets control bit 7. A low-to-high transition does not.
- R6: With control bit 1 = 1, a low-to-high transition of `c1_in` sets control bit 7.
- R7: A `c1_in` transition applied between two edges sets the flag on the third rising clock edge after it, and not before.
- R8: `irq_n` is 0 exactly while control bit 7 and control bit 0 are both 1. Setting or clearing bit 0 while the flag is set changes `irq_n` right after the write edge.
- R9: A read of the data address with control bit 2 = 1 clears bit 7. A read of the control address does not clear it, and neither does a data-address read with bit 2 = 0.
- R10: Control writes update only bits 5 to 0. Bit 7 ignores the written value, and bit 6 always reads 0.
- R11: `c2_oe` equals control bit 5. `c2_out` is 1 only when bits 5, 4 and 3 are all 1; otherwise it is 0.
- R12: If an active C1 edge and a flag-clearing read fall on the same clock edge, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 1 | Bus access strobe, one cycle per access |
| addr | input | 1 | 0 selects the data address, 1 selects the control address |
| wr | input | 1 | 1 = write, 0 = read |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data (combinational from `addr`) |
| pin_in | input | DW | Port pin levels |
| pin_out | output | DW | Output register value |
| pin_oe | output | DW | Per-pin output enable (the direction register) |
| c1_in | input | 1 | Control line 1, asynchronous input |
| c2_out | output | 1 | Control line 2 level |
| c2_oe | output | 1 | Control line 2 output enable |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
The results arrive on three different schedules:
- **Register writes:** their effects, and the effects of control writes on `irq_n`, `c2_*` and `pin_oe`, are due right after the clock edge on which `sel` is high. The bench drives and samples at the falling edge, so it checks them at the next falling edge.
- **Pin levels:** these pass through one sampling register. The bench changes `pin_in` at a falling edge, expects the old level until the next rising edge, and expects the new level one cycle later.
- **C1 edges:** these pass through two synchronizer stages and one history stage. The bench checks that `irq_n` is still high after the second rising edge following the change and low after the third. It aligns a clearing read onto that third edge to check that setting the flag takes priority over clearing it.

// File: rtl/ppp_pkg.sv
package ppp_pkg;
   localparam int CTRL_W    = 8;
   localparam int CB_EN     = 0;  // interrupt enable
   localparam int CB_POL    = 1;  // C1 edge select
   localparam int CB_DSEL   = 2;  // data address: 0 direction, 1 pins
   localparam int CB_C2LVL  = 3;  // C2 manual level
   localparam int CB_C2MAN  = 4;  // C2 manual mode
   localparam int CB_C2DIR  = 5;  // C2 direction
   localparam int CB_FLAG2  = 6;  // unused flag, reads zero
   localparam int CB_FLAG1  = 7;  // C1 flag
   localparam int CFG_W     = CB_C2DIR + 1;
endpackage

// File: rtl/ppp_sync.sv
module ppp_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   input  logic rise_sel,
   output logic edge_hit
);
   localparam int CHAIN_W = STAGES + 1;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("ppp_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [CHAIN_W-1:0] chain_q;
   logic               now_lvl;
   logic               old_lvl;

   always_ff @(posedge clk) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[CHAIN_W-2:0], async_in};
   end

   assign now_lvl  = chain_q[STAGES-1];
   assign old_lvl  = chain_q[STAGES];
   assign edge_hit = rise_sel ? (now_lvl & ~old_lvl) : (~now_lvl & old_lvl);

   // A detected edge always corresponds to a level change between stages
   AST_HIT_IS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      edge_hit |=> (chain_q[STAGES] != $past(chain_q[STAGES]))); // R7
endmodule

// File: rtl/ppp_ctrl.sv
module ppp_ctrl
   import ppp_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_ctrl,
   input  logic [CTRL_W-1:0] wval,
   input  logic              rd_clr,
   input  logic              edge_hit,
   output logic [CTRL_W-1:0] ctrl_q
);
   logic [CFG_W-1:0] cfg_q;
   logic             flag_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else if (wr_ctrl) begin
         cfg_q <= wval[CFG_W-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        flag_q <= 1'b0;
      else if (edge_hit) flag_q <= 1'b1;
      else if (rd_clr)   flag_q <= 1'b0;
   end

   always_comb begin
      ctrl_q            = '0;
      ctrl_q[CFG_W-1:0] = cfg_q;
      ctrl_q[CB_FLAG2]  = 1'b0;
      ctrl_q[CB_FLAG1]  = flag_q;
   end

   AST_FLAG_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q) |-> $past(edge_hit)); // R5

   AST_FLAG_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_clr && !edge_hit) |=> !flag_q); // R9

   AST_FLAG_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && !edge_hit) |=> $stable(flag_q)); // R10

   AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      edge_hit |=> flag_q); // R12
endmodule

// File: rtl/ppp_data.sv
module ppp_data #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_data,
   input  logic          dsel,
   input  logic [DW-1:0] wval,
   input  logic [DW-1:0] pin_in,
   output logic [DW-1:0] ddr_q,
   output logic [DW-1:0] out_q,
   output logic [DW-1:0] rd_val
);
   logic [DW-1:0] pin_q;
   logic [DW-1:0] pin_view;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ddr_q <= '0;
         out_q <= '0;
         pin_q <= '0;
      end else begin
         pin_q <= pin_in;
         if (wr_data && !dsel) ddr_q <= wval;
         if (wr_data &&  dsel) out_q <= wval;
      end
   end

   generate
      for (genvar i = 0; i < DW; i++) begin : g_bit
         assign pin_view[i] = ddr_q[i] ? out_q[i] : pin_q[i];
      end
   endgenerate

   assign rd_val = dsel ? pin_view : ddr_q;

   AST_DDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_data && !dsel) |=> $stable(ddr_q)); // R2

   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_data && dsel) |=> $stable(out_q)); // R3
endmodule

// File: rtl/ppp_side.sv
module ppp_side
   import ppp_pkg::*;
#(
   parameter int DW          = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sel,
   input  logic          addr,
   input  logic          wr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata,
   input  logic [DW-1:0] pin_in,
   output logic [DW-1:0] pin_out,
   output logic [DW-1:0] pin_oe,
   input  logic          c1_in,
   output logic          c2_out,
   output logic          c2_oe,
   output logic          irq_n
);
   generate
      if (DW < CTRL_W) begin : g_bad_width
         $error("ppp_side: DW must be at least the control width");
      end
   endgenerate

   logic              wr_ctrl;
   logic              wr_data;
   logic              rd_clr;
   logic              edge_hit;
   logic [CTRL_W-1:0] ctrl_q;
   logic [DW-1:0]     data_rd;

   assign wr_ctrl = sel &  wr &  addr;
   assign wr_data = sel &  wr & ~addr;
   assign rd_clr  = sel & ~wr & ~addr & ctrl_q[CB_DSEL];

   ppp_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (c1_in),
      .rise_sel (ctrl_q[CB_POL]),
      .edge_hit (edge_hit)
   );

   ppp_ctrl ctrl_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_ctrl  (wr_ctrl),
      .wval     (wdata[CTRL_W-1:0]),
      .rd_clr   (rd_clr),
      .edge_hit (edge_hit),
      .ctrl_q   (ctrl_q)
   );

   ppp_data #(.DW(DW)) data_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_data (wr_data),
      .dsel    (ctrl_q[CB_DSEL]),
      .wval    (wdata),
      .pin_in  (pin_in),
      .ddr_q   (pin_oe),
      .out_q   (pin_out),
      .rd_val  (data_rd)
   );

   always_comb begin
      if (addr) begin
         rdata             = '0;
         rdata[CTRL_W-1:0] = ctrl_q;
      end else begin
         rdata = data_rd;
      end
   end

   assign c2_oe  = ctrl_q[CB_C2DIR];
   assign c2_out = ctrl_q[CB_C2DIR] & ctrl_q[CB_C2MAN] & ctrl_q[CB_C2LVL];
   assign irq_n  = ~(ctrl_q[CB_FLAG1] & ctrl_q[CB_EN]);

   AST_C2_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !c2_oe |-> !c2_out); // R11

   AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_n && !$past(irq_n) && !$past(wr_ctrl)) |-> $past(ctrl_q[CB_FLAG1])); // R8
endmodule

// File: tb/ppp_side_tb_top.sv
module ppp_side_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sel = 1'b0;
   logic       addr = 1'b0;
   logic       wr = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic [7:0] pin_in = '0;
   logic [7:0] pin_out;
   logic [7:0] pin_oe;
   logic       c1_in = 1'b0;
   logic       c2_out;
   logic       c2_oe;
   logic       irq_n;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   ppp_side #(.DW(8), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .sel(sel), .addr(addr), .wr(wr),
      .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out),
      .pin_oe(pin_oe), .c1_in(c1_in), .c2_out(c2_out), .c2_oe(c2_oe),
      .irq_n(irq_n)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic bus_wr(input logic a, input logic [7:0] d);
      @(negedge clk);
      sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      sel = 1'b0; wr = 1'b0;
   endtask

   task automatic bus_rd(input logic a, output logic [7:0] d);
      @(negedge clk);
      sel = 1'b1; wr = 1'b0; addr = a;
      #1 d = rdata;
      @(negedge clk);
      sel = 1'b0;
   endtask

   // {wr, addr, data, expected read, requirement number}
   localparam int NV = 12;
   localparam logic [21:0] VEC [0:NV-1] = '{
      {1'b1, 1'b0, 8'hF0, 8'h00, 4'd2},   // R2 direction load
      {1'b0, 1'b0, 8'h00, 8'hF0, 4'd2},   // R2 direction readback
      {1'b1, 1'b1, 8'h04, 8'h00, 4'd10},
      {1'b0, 1'b1, 8'h00, 8'h04, 4'd10},  // R10
      {1'b1, 1'b0, 8'hA5, 8'h00, 4'd3},   // R3 output load
      {1'b0, 1'b0, 8'h00, 8'hAC, 4'd3},   // R3 R4 mixed read
      {1'b1, 1'b1, 8'hC0, 8'h00, 4'd10},  // R10 top bits ignored
      {1'b0, 1'b1, 8'h00, 8'h00, 4'd10},
      {1'b0, 1'b0, 8'h00, 8'hF0, 4'd2},   // R2 back to direction
      {1'b1, 1'b1, 8'h04, 8'h00, 4'd3},
      {1'b0, 1'b0, 8'h00, 8'hAC, 4'd3},   // R3
      {1'b0, 1'b1, 8'h00, 8'h04, 4'd10}
   };

   initial begin
      logic [7:0] rd;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 pin_oe", pin_oe, 8'h00);
      check("R1 c2_oe", {7'd0, c2_oe}, 8'h00);
      check("R1 irq_n", {7'd0, irq_n}, 8'h01);
      bus_rd(1'b1, rd); check("R1 ctrl", rd, 8'h00);

      pin_in = 8'h3C;
      for (int i = 0; i < NV; i++) begin
         if (VEC[i][21]) begin
            bus_wr(VEC[i][20], VEC[i][19:12]);
         end else begin
            bus_rd(VEC[i][20], rd);
            check($sformatf("R%0d vector %0d", VEC[i][3:0], i), rd, VEC[i][11:4]);
         end
      end
      check("R2 pin_oe", pin_oe, 8'hF0);
      check("R3 pin_out", pin_out, 8'hA5);

      // R4 input sampling delay
      addr = 1'b0;
      @(negedge clk);
      pin_in = 8'h35;
      #1 check("R4 before edge", rdata, 8'hAC);
      @(negedge clk);
      #1 check("R4 after edge", rdata, 8'hA5);

      // R5 falling mode: rising ignored
      bus_wr(1'b1, 8'h05);
      @(negedge clk); c1_in = 1'b1;
      repeat (5) @(negedge clk);
      check("R5 rising ignored irq", {7'd0, irq_n}, 8'h01);
      bus_rd(1'b1, rd); check("R5 rising ignored ctrl", rd, 8'h05);
      // R7 timing of falling edge
      @(negedge clk); c1_in = 1'b0;
      @(negedge clk);
      @(negedge clk);
      #1 check("R7 not yet", {7'd0, irq_n}, 8'h01);
      @(negedge clk);
      #1 check("R7 third edge", {7'd0, irq_n}, 8'h00);
      bus_rd(1'b1, rd); check("R5 flag set", rd, 8'h85);

      // R9 clear rules
      check("R9 ctrl read keeps flag", {7'd0, irq_n}, 8'h00);
      bus_wr(1'b1, 8'h01);
      bus_rd(1'b0, rd);
      check("R9 direction read keeps flag", {7'd0, irq_n}, 8'h00);
      bus_wr(1'b1, 8'h05);
      bus_rd(1'b0, rd);
      check("R9 data read clears irq", {7'd0, irq_n}, 8'h01);
      bus_rd(1'b1, rd); check("R9 flag cleared", rd, 8'h05);

      // R6 rising mode, R8 enable gating
      bus_wr(1'b1, 8'h06);
      @(negedge clk); c1_in = 1'b1;
      repeat (4) @(negedge clk);
      check("R8 disabled irq", {7'd0, irq_n}, 8'h01);
      bus_rd(1'b1, rd); check("R6 rising sets flag", rd, 8'h86);
      bus_wr(1'b1, 8'h07);
      check("R8 enable asserts irq", {7'd0, irq_n}, 8'h00);
      bus_wr(1'b1, 8'h06);
      check("R8 disable releases irq", {7'd0, irq_n}, 8'h01);

      // R12 set wins over clear
      bus_wr(1'b1, 8'h05);
      bus_rd(1'b0, rd);
      check("R12 pre-clear", {7'd0, irq_n}, 8'h01);
      @(negedge clk); c1_in = 1'b0;
      @(posedge clk);
      @(posedge clk);
      bus_rd(1'b0, rd);
      bus_rd(1'b1, rd); check("R12 flag survives", rd, 8'h85);

      // R11 C2 manual output
      bus_wr(1'b1, 8'h38);
      check("R11 oe 38", {7'd0, c2_oe}, 8'h01);
      check("R11 out 38", {7'd0, c2_out}, 8'h01);
      bus_wr(1'b1, 8'h30);
      check("R11 out 30", {7'd0, c2_out}, 8'h00);
      bus_wr(1'b1, 8'h28);
      check("R11 oe 28", {7'd0, c2_oe}, 8'h01);
      check("R11 out 28", {7'd0, c2_out}, 8'h00);
      bus_wr(1'b1, 8'h18);
      check("R11 oe 18", {7'd0, c2_oe}, 8'h00);
      check("R11 out 18", {7'd0, c2_out}, 8'h00);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule